// File: doc/BRIEF.md
# Bulk Endpoint Buffer with Loss-Free Handshakes

This block is the data path of one bidirectional bulk endpoint pair in a full-speed USB device. On one side it faces a packet-level engine that has already decoded tokens, stripped framing and checked CRC. That engine presents a token strobe, a byte strobe for received payload, an end-of-packet strobe carrying the received data toggle, and a strobe for the host's acknowledge. On the other side it offers two byte-wide valid/ready streams to the application. One carries host-to-device (OUT) bytes and the other carries device-to-host (IN) bytes.

Both directions use register-only FIFOs with two pointers on one end: a speculative pointer that moves byte by byte and a committed pointer that moves only on a handshake. An OUT packet is written speculatively. It is committed and acknowledged only if the free space sampled at its token could hold a maximum-size packet. Otherwise it is rewound and refused with NAK, so the host's retry finds the buffer unchanged. An IN packet is read speculatively and is rewound for a resend until the host acknowledges it. When nothing is queued, the endpoint answers NAK.

The engine returns the handshake code from `hs_code` while `hs_valid` is high. For IN data it frames a packet of `tx_len` bytes after `tx_start` and pulls the bytes with `tx_ready`.

Top module: `bulk_ep_nak`

## Requirements
- R1: After reset, `hs_valid`, `tx_start`, `tx_valid` and `app_out_valid` are low, and `app_in_ready` is high.
- R2: An OUT packet of at most OUT_MAX bytes with the expected toggle, whose token found at least OUT_MAX free bytes, is acknowledged with `hs_valid` high and `hs_code` = 2'b01 (ACK) in the cycle after `rx_end`. Its bytes then appear on the application OUT port in arrival order.
- R3: An OUT packet whose token found fewer than OUT_MAX free bytes is answered with `hs_code` = 2'b10 (NAK) one cycle after `rx_end`. None of its bytes reach the application, and the same packet is accepted after the application drains the buffer.
- R4: The OUT toggle starts at DATA0 (`rx_odd` = 0) and flips after each committed packet. A packet with the wrong toggle is acknowledged with ACK but discarded.
- R5: An OUT packet longer than OUT_MAX bytes gets no handshake, delivers no byte and leaves the OUT toggle unchanged.
- R6: An IN token finds no queued byte and no pending zero-length packet. The endpoint then answers NAK (`hs_code` = 2'b10) in the next cycle, without `tx_start`.
- R7: An IN token with queued bytes raises `tx_start` in the next cycle. With it come `tx_len` = min(queued, IN_MAX) and `tx_odd` equal to the IN toggle, which starts at DATA0. Exactly `tx_len` bytes then follow in queue order, and no handshake is raised in that cycle.
- R8: An IN packet that was not acknowledged is resent unchanged on the next IN token: same length, bytes and toggle. Bytes queued after it do not join it.
- R9: A host acknowledge after a complete IN packet releases its bytes and flips the IN toggle.
- R10: After an acknowledged IN packet of exactly IN_MAX bytes, an IN token that finds an empty buffer gets a zero-length packet (`tx_start` with `tx_len` = 0 and no `tx_valid`). Once that packet is acknowledged, the next empty IN token is NAKed.
- R11: Application and engine byte streams transfer on an edge where valid and ready are both high. A byte offered and not taken stays unchanged. `app_in_ready` falls once IN_DEPTH bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tok_valid | input | 1 | Token strobe for this endpoint pair |
| tok_in | input | 1 | Token direction: 1 IN, 0 OUT |
| rx_valid | input | 1 | OUT payload byte strobe |
| rx_byte | input | 8 | OUT payload byte |
| rx_end | input | 1 | End of OUT data packet (CRC already good) |
| rx_odd | input | 1 | Toggle of the received packet: 0 DATA0, 1 DATA1 |
| host_ack | input | 1 | Host acknowledged the last IN packet |
| hs_valid | output | 1 | Handshake to send |
| hs_code | output | 2 | 2'b01 ACK, 2'b10 NAK |
| tx_start | output | 1 | An IN data packet begins |
| tx_len | output | IN_LW | Payload length of that packet |
| tx_odd | output | 1 | Toggle of that packet |
| tx_valid | output | 1 | IN payload byte offered |
| tx_byte | output | 8 | IN payload byte |
| tx_ready | input | 1 | Engine takes the IN byte |
| app_out_valid | output | 1 | Received byte available |
| app_out_data | output | 8 | Received byte |
| app_out_ready | input | 1 | Application takes the byte |
| app_in_valid | input | 1 | Application offers a byte |
| app_in_data | input | 8 | Byte to send to the host |
| app_in_ready | output | 1 | Endpoint accepts the byte |

## Verification
Directed OUT packets differ in length (short, full, one over the limit), in toggle (matching or repeated) and in buffer fill (drained or stalled by the application). Together they separate the ACK-commit, ACK-discard, NAK and silent-drop outcomes. Directed IN sequences cover an empty buffer, a short packet, an unacknowledged resend while new bytes arrive, and a full packet followed by an empty buffer. They tell a true resend from a fresh read and a zero-length packet from a NAK. Seeded random traffic then mixes OUT packets with occasional bad toggles and oversize lengths, IN tokens with and without acknowledge, and random ready/valid patterns on all streams. A bench model predicts every handshake, length and byte.

// File: rtl/bep_pkg.sv
package bep_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        HS_NONE = 2'b00,
        HS_ACK  = 2'b01,
        HS_NAK  = 2'b10
    } hs_code_t;

    typedef enum logic [1:0] {
        TXS_IDLE = 2'b00,
        TXS_SEND = 2'b01,
        TXS_WAIT = 2'b10
    } tx_state_t;

endpackage

// File: rtl/bep_fifo.sv
// Register FIFO with a speculative and a committed pointer on each end.
// Writers and readers advance the speculative pointers; commit copies the
// speculative pointer into the committed one, rewind does the opposite.
module bep_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [bep_pkg::BYTE_W-1:0] wr_data,
    input  logic                      wr_commit,
    input  logic                      wr_rewind,
    input  logic                      rd_en,
    input  logic                      rd_commit,
    input  logic                      rd_rewind,
    output logic [bep_pkg::BYTE_W-1:0] rd_data,
    output logic [AW:0]               avail,
    output logic [AW:0]               space
);

    typedef struct packed {
        logic [AW:0] wr_spec;
        logic [AW:0] wr_cmt;
        logic [AW:0] rd_spec;
        logic [AW:0] rd_cmt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic wr_go, rd_go;
    logic [bep_pkg::BYTE_W-1:0] mem_q [DEPTH];

    always_comb begin
        avail = ptr_q.wr_cmt - ptr_q.rd_spec;
        space = (AW+1)'(DEPTH) - (ptr_q.wr_spec - ptr_q.rd_cmt);
        wr_go = wr_en && (space != '0) && !wr_rewind;
        rd_go = rd_en && (avail != '0) && !rd_rewind;

        ptr_d = ptr_q;
        ptr_d.wr_spec = wr_rewind ? ptr_q.wr_cmt : ptr_q.wr_spec + (AW+1)'(wr_go);
        ptr_d.rd_spec = rd_rewind ? ptr_q.rd_cmt : ptr_q.rd_spec + (AW+1)'(rd_go);
        if (wr_commit) ptr_d.wr_cmt = ptr_d.wr_spec;
        if (rd_commit) ptr_d.rd_cmt = ptr_d.rd_spec;

        rd_data = mem_q[ptr_q.rd_spec[AW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // storage carries no reset: only committed entries are ever read
    always_ff @(posedge clk) begin
        if (wr_go) mem_q[ptr_q.wr_spec[AW-1:0]] <= wr_data;
    end

endmodule

// File: rtl/bep_out_ctrl.sv
// Host-to-device side: decides commit, discard, ACK or NAK per packet.
module bep_out_ctrl #(
    parameter int OUT_MAX = 8,
    parameter int AW      = 4,
    localparam int CW     = $clog2(OUT_MAX + 1) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tok_out,
    input  logic        rx_valid,
    input  logic        rx_end,
    input  logic        rx_odd,
    input  logic [AW:0] space,
    output logic        wr_en,
    output logic        wr_commit,
    output logic        wr_rewind,
    output logic        hs_valid,
    output logic [1:0]  hs_code
);
    import bep_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fits;
        logic          tog;
        logic          hs_v;
        hs_code_t      hs_c;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hs_v = 1'b0;
        st_d.hs_c = HS_NONE;
        wr_en     = 1'b0;
        wr_commit = 1'b0;
        wr_rewind = 1'b0;

        if (tok_out) begin
            st_d.cnt  = '0;
            st_d.fits = (space >= (AW+1)'(OUT_MAX));
            wr_rewind = 1'b1;
        end else if (rx_valid) begin
            if (st_q.cnt <= CW'(OUT_MAX)) st_d.cnt = st_q.cnt + CW'(1);
            wr_en = st_q.fits && (st_q.cnt < CW'(OUT_MAX));
        end else if (rx_end) begin
            st_d.cnt  = '0;
            st_d.fits = 1'b0;
            if (st_q.cnt > CW'(OUT_MAX)) begin
                wr_rewind = 1'b1;               // babble: silent drop
            end else if (!st_q.fits) begin
                wr_rewind = 1'b1;
                st_d.hs_v = 1'b1;
                st_d.hs_c = HS_NAK;
            end else if (rx_odd != st_q.tog) begin
                wr_rewind = 1'b1;               // repeat of a packet already taken
                st_d.hs_v = 1'b1;
                st_d.hs_c = HS_ACK;
            end else begin
                wr_commit = 1'b1;
                st_d.tog  = ~st_q.tog;
                st_d.hs_v = 1'b1;
                st_d.hs_c = HS_ACK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, fits: 1'b0, tog: 1'b0, hs_v: 1'b0, hs_c: HS_NONE};
        else        st_q <= st_d;
    end

    assign hs_valid = st_q.hs_v;
    assign hs_code  = st_q.hs_c;

endmodule

// File: rtl/bep_in_ctrl.sv
// Device-to-host side: builds packets, holds them until acknowledged.
module bep_in_ctrl #(
    parameter int IN_MAX = 8,
    parameter int AW     = 4,
    localparam int LW    = $clog2(IN_MAX) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          host_ack,
    input  logic          tx_ready,
    input  logic [AW:0]   avail,
    output logic          rd_en,
    output logic          rd_commit,
    output logic          rd_rewind,
    output logic          tx_start,
    output logic [LW-1:0] tx_len,
    output logic          tx_odd,
    output logic          tx_valid,
    output logic          hs_valid
);
    import bep_pkg::*;

    typedef struct packed {
        tx_state_t     st;
        logic          held;
        logic [LW-1:0] len;
        logic [LW-1:0] rem;
        logic          tog;
        logic          zlp;
        logic          start;
        logic          nak;
    } in_st_t;

    in_st_t st_d, st_q;
    logic [LW-1:0] take;

    always_comb begin
        take = (avail > (AW+1)'(IN_MAX)) ? LW'(IN_MAX) : LW'(avail);
        tx_valid = (st_q.st == TXS_SEND) && (st_q.rem != '0);

        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.nak   = 1'b0;
        rd_en      = 1'b0;
        rd_commit  = 1'b0;
        rd_rewind  = 1'b0;

        unique case (st_q.st)
            TXS_SEND: begin
                if (st_q.rem == '0) begin
                    st_d.st = TXS_WAIT;
                end else if (tx_ready) begin
                    rd_en    = 1'b1;
                    st_d.rem = st_q.rem - LW'(1);
                    if (st_q.rem == LW'(1)) st_d.st = TXS_WAIT;
                end
            end
            default: begin
                if (tok_in) begin
                    if (st_q.held) begin
                        rd_rewind  = 1'b1;
                        st_d.rem   = st_q.len;
                        st_d.start = 1'b1;
                        st_d.st    = TXS_SEND;
                    end else if (take != '0 || st_q.zlp) begin
                        st_d.held  = 1'b1;
                        st_d.len   = take;
                        st_d.rem   = take;
                        st_d.start = 1'b1;
                        st_d.st    = TXS_SEND;
                    end else begin
                        st_d.nak = 1'b1;
                    end
                end else if (st_q.st == TXS_WAIT && host_ack) begin
                    rd_commit = 1'b1;
                    st_d.held = 1'b0;
                    st_d.tog  = ~st_q.tog;
                    st_d.zlp  = (st_q.len == LW'(IN_MAX));
                    st_d.st   = TXS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: TXS_IDLE, held: 1'b0, len: '0, rem: '0,
                              tog: 1'b0, zlp: 1'b0, start: 1'b0, nak: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_start = st_q.start;
    assign tx_len   = st_q.len;
    assign tx_odd   = st_q.tog;
    assign hs_valid = st_q.nak;

endmodule

// File: rtl/bulk_ep_nak.sv
module bulk_ep_nak #(
    parameter int IN_MAX    = 8,
    parameter int OUT_MAX   = 8,
    parameter int IN_DEPTH  = 2 * IN_MAX,
    parameter int OUT_DEPTH = 2 * OUT_MAX,
    localparam int IN_LW    = $clog2(IN_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic             tok_in,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_end,
    input  logic             rx_odd,
    input  logic             host_ack,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             tx_start,
    output logic [IN_LW-1:0] tx_len,
    output logic             tx_odd,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    output logic             app_out_valid,
    output logic [7:0]       app_out_data,
    input  logic             app_out_ready,
    input  logic             app_in_valid,
    input  logic [7:0]       app_in_data,
    output logic             app_in_ready
);
    import bep_pkg::*;

    localparam int OAW = $clog2(OUT_DEPTH);
    localparam int IAW = $clog2(IN_DEPTH);

    logic [OAW:0] o_avail, o_space;
    logic [IAW:0] i_avail, i_space;
    logic o_wr_en, o_commit, o_rewind, o_hs_v;
    logic [1:0] o_hs_c;
    logic i_rd_en, i_commit, i_rewind, i_nak;

    bep_out_ctrl #(.OUT_MAX(OUT_MAX), .AW(OAW)) u_out_ctrl (
        .clk, .rst_n,
        .tok_out   (tok_valid && !tok_in),
        .rx_valid, .rx_end, .rx_odd,
        .space     (o_space),
        .wr_en     (o_wr_en),
        .wr_commit (o_commit),
        .wr_rewind (o_rewind),
        .hs_valid  (o_hs_v),
        .hs_code   (o_hs_c)
    );

    bep_fifo #(.DEPTH(OUT_DEPTH)) u_out_fifo (
        .clk, .rst_n,
        .wr_en     (o_wr_en),
        .wr_data   (rx_byte),
        .wr_commit (o_commit),
        .wr_rewind (o_rewind),
        .rd_en     (app_out_valid && app_out_ready),
        .rd_commit (1'b1),
        .rd_rewind (1'b0),
        .rd_data   (app_out_data),
        .avail     (o_avail),
        .space     (o_space)
    );

    bep_in_ctrl #(.IN_MAX(IN_MAX), .AW(IAW)) u_in_ctrl (
        .clk, .rst_n,
        .tok_in    (tok_valid && tok_in),
        .host_ack, .tx_ready,
        .avail     (i_avail),
        .rd_en     (i_rd_en),
        .rd_commit (i_commit),
        .rd_rewind (i_rewind),
        .tx_start, .tx_len, .tx_odd, .tx_valid,
        .hs_valid  (i_nak)
    );

    bep_fifo #(.DEPTH(IN_DEPTH)) u_in_fifo (
        .clk, .rst_n,
        .wr_en     (app_in_valid && app_in_ready),
        .wr_data   (app_in_data),
        .wr_commit (1'b1),
        .wr_rewind (1'b0),
        .rd_en     (i_rd_en),
        .rd_commit (i_commit),
        .rd_rewind (i_rewind),
        .rd_data   (tx_byte),
        .avail     (i_avail),
        .space     (i_space)
    );

    assign app_out_valid = (o_avail != '0);
    assign app_in_ready  = (i_space != '0);
    assign hs_valid      = o_hs_v | i_nak;
    assign hs_code       = o_hs_v ? o_hs_c : (i_nak ? 2'(HS_NAK) : 2'(HS_NONE));

endmodule

// File: rtl/bep_checks.sv
module bep_checks #(
    parameter int IN_MAX = 8,
    parameter int IN_LW  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_valid,
    input logic [1:0]       hs_code,
    input logic             tx_start,
    input logic [IN_LW-1:0] tx_len,
    input logic             tx_valid,
    input logic [7:0]       tx_byte,
    input logic             tx_ready,
    input logic             app_out_valid,
    input logic [7:0]       app_out_data,
    input logic             app_out_ready
);

    logic [7:0]       sent_q;
    logic [IN_LW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q <= '0;
            len_q  <= '0;
        end else if (tx_start) begin
            sent_q <= (tx_valid && tx_ready) ? 8'd1 : 8'd0;
            len_q  <= tx_len;
        end else if (tx_valid && tx_ready) begin
            sent_q <= sent_q + 8'd1;
        end
    end

    assert_hs_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code == 2'b01 || hs_code == 2'b10));

    assert_nak_xor_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_valid && tx_start));

    assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_len <= IN_LW'(IN_MAX)));

    assert_byte_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q <= 8'(len_q));

    assert_zlp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_len == '0) |-> !tx_valid);

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (app_out_valid && !app_out_ready) |=> (app_out_valid && $stable(app_out_data)));

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

endmodule

bind bulk_ep_nak bep_checks #(.IN_MAX(IN_MAX), .IN_LW(IN_LW)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_valid      (hs_valid),
    .hs_code       (hs_code),
    .tx_start      (tx_start),
    .tx_len        (tx_len),
    .tx_valid      (tx_valid),
    .tx_byte       (tx_byte),
    .tx_ready      (tx_ready),
    .app_out_valid (app_out_valid),
    .app_out_data  (app_out_data),
    .app_out_ready (app_out_ready)
);

// File: tb/sim_bulk_ep_nak.sv
`timescale 1ns/1ps
module sim_bulk_ep_nak;

    localparam int IN_MAX    = 8;
    localparam int OUT_MAX   = 8;
    localparam int IN_DEPTH  = 16;
    localparam int OUT_DEPTH = 16;
    localparam int IN_LW     = $clog2(IN_MAX) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_valid = 0, tok_in = 0, rx_valid = 0, rx_end = 0, rx_odd = 0, host_ack = 0;
    logic [7:0] rx_byte = 0;
    logic hs_valid, tx_start, tx_odd, tx_valid, app_out_valid, app_in_ready;
    logic [1:0] hs_code;
    logic [IN_LW-1:0] tx_len;
    logic [7:0] tx_byte, app_out_data;
    logic tx_ready = 1, app_out_ready = 0, app_in_valid = 0;
    logic [7:0] app_in_data = 0;

    always #4 clk = ~clk;

    bulk_ep_nak #(.IN_MAX(IN_MAX), .OUT_MAX(OUT_MAX), .IN_DEPTH(IN_DEPTH),
                  .OUT_DEPTH(OUT_DEPTH)) u0 (.*);

    int checks = 0, errors = 0;
    int rdy_mode = 0;               // 0 stall, 1 always, 2 random
    bit out_tog = 0, in_tog = 0, zlp_pend = 0, held = 0;
    int held_len = 0;
    logic [7:0] exp_out_q[$], in_q[$], feed_q[$], tx_got[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic upd_prod();
        app_in_valid = (feed_q.size() != 0);
        app_in_data  = (feed_q.size() != 0) ? feed_q[0] : 8'h00;
    endtask

    // one clock: record transfers of the coming edge, then refresh random readies
    task automatic tick();
        if (app_out_valid && app_out_ready) begin
            if (exp_out_q.size() == 0) check(0, "R2 unexpected OUT byte", app_out_data, -1);
            else begin
                check(app_out_data == exp_out_q[0], "R2 OUT byte order", app_out_data, exp_out_q[0]);
                void'(exp_out_q.pop_front());
            end
        end
        if (app_in_valid && app_in_ready) in_q.push_back(feed_q.pop_front());
        if (tx_valid && tx_ready) tx_got.push_back(tx_byte);
        @(posedge clk);
        @(negedge clk);
        app_out_ready = (rdy_mode == 2) ? 1'($urandom % 2) : 1'(rdy_mode);
        tx_ready = ($urandom % 4) != 0;
        upd_prod();
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) feed_q.push_back(8'($urandom));
        upd_prod();
    endtask

    // result: 0 none, 1 ACK, 2 NAK
    task automatic do_out(input int len, input bit odd, output int res);
        bit fits;
        int exp_res;
        logic [7:0] pkt[$];
        fits = (OUT_DEPTH - exp_out_q.size()) >= OUT_MAX;
        tok_valid = 1; tok_in = 0;
        tick();
        tok_valid = 0;
        for (int i = 0; i < len; i++) begin
            pkt.push_back(8'($urandom));
            rx_valid = 1; rx_byte = pkt[i];
            tick();
        end
        rx_valid = 0;
        rx_end = 1; rx_odd = odd;
        tick();
        rx_end = 0;
        res = !hs_valid ? 0 : (hs_code == 2'b01 ? 1 : (hs_code == 2'b10 ? 2 : 3));
        if (len > OUT_MAX) exp_res = 0;
        else if (!fits) exp_res = 2;
        else exp_res = 1;
        check(res == exp_res, (len > OUT_MAX) ? "R5 oversize handshake" :
              (!fits ? "R3 OUT NAK" : (odd != out_tog ? "R4 repeat ACK" : "R2 OUT ACK")),
              res, exp_res);
        if (len <= OUT_MAX && fits && odd == out_tog) begin
            foreach (pkt[i]) exp_out_q.push_back(pkt[i]);
            out_tog = ~out_tog;
        end
    endtask

    // result: 0 NAK, 1 data packet
    task automatic do_in(input bit ack, output int res);
        int elen;
        bit nak;
        if (held) begin elen = held_len; nak = 0; end
        else begin
            elen = (in_q.size() > IN_MAX) ? IN_MAX : in_q.size();
            nak  = (elen == 0) && !zlp_pend;
        end
        tok_valid = 1; tok_in = 1;
        tick();
        tok_valid = 0; tok_in = 0;
        tx_got.delete();
        if (nak) begin
            check(hs_valid && hs_code == 2'b10 && !tx_start, "R6 IN NAK", {hs_valid, hs_code, tx_start}, 3'b110);
            res = 0;
            return;
        end
        res = 1;
        check(tx_start && !hs_valid, "R7 tx_start", {tx_start, hs_valid}, 2'b10);
        check(tx_len == IN_LW'(elen), held ? "R8 resend length" : "R7 length", tx_len, elen);
        check(tx_odd == in_tog, held ? "R8 resend toggle" : "R7 toggle", tx_odd, in_tog);
        if (elen == 0) check(!tx_valid, "R10 zero-length has no byte", tx_valid, 0);
        for (int k = 0; k < 400 && tx_got.size() < elen; k++) tick();
        tick();
        check(tx_got.size() == elen, "R7 byte count", tx_got.size(), elen);
        for (int i = 0; i < tx_got.size() && i < elen; i++)
            check(tx_got[i] == in_q[i], held ? "R8 resend byte" : "R7 byte", tx_got[i], in_q[i]);
        if (ack) begin
            host_ack = 1;
            tick();
            host_ack = 0;
            for (int i = 0; i < elen; i++) void'(in_q.pop_front());
            in_tog   = ~in_tog;
            zlp_pend = (elen == IN_MAX);
            held     = 0;
        end else begin
            held = 1; held_len = elen;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int r;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!hs_valid && !tx_start && !tx_valid, "R1 engine outputs idle", {hs_valid, tx_start, tx_valid}, 0);
        check(!app_out_valid && app_in_ready, "R1 app ports", {app_out_valid, app_in_ready}, 1);

        // R6 empty IN
        do_in(1, r);
        check(r == 0, "R6 empty IN is NAK", r, 0);

        // R2 simple OUT
        rdy_mode = 1;
        do_out(5, 0, r);
        repeat (8) tick();
        check(exp_out_q.size() == 0, "R2 all bytes delivered", exp_out_q.size(), 0);

        // R4 repeated toggle (expected now DATA1)
        do_out(4, 0, r);
        check(r == 1, "R4 repeat still ACKed", r, 1);
        repeat (6) tick();
        check(!app_out_valid, "R4 repeat discarded", app_out_valid, 0);

        // R5 oversize, toggle must stay DATA1
        do_out(OUT_MAX + 1, 1, r);
        repeat (6) tick();
        check(!app_out_valid, "R5 oversize discarded", app_out_valid, 0);
        do_out(3, 1, r);
        check(r == 1 && out_tog == 0, "R5 toggle unchanged after oversize", r, 1);
        repeat (6) tick();

        // R3 buffer full -> NAK, then retry after drain
        rdy_mode = 0;
        repeat (2) tick();
        do_out(OUT_MAX, 0, r);
        do_out(OUT_MAX, 1, r);
        do_out(OUT_MAX, 0, r);
        check(r == 2, "R3 third full packet NAKed", r, 2);
        rdy_mode = 1;
        repeat (40) tick();
        check(exp_out_q.size() == 0, "R3 NAKed bytes never delivered", exp_out_q.size(), 0);
        do_out(OUT_MAX, 0, r);
        check(r == 1, "R3 retry accepted", r, 1);
        repeat (12) tick();

        // R7/R8/R9 IN short packet, resend, ack
        feed(5);
        repeat (8) tick();
        do_in(0, r);
        feed(3);
        repeat (6) tick();
        do_in(1, r);            // resend, then R9 ack
        check(in_q.size() == 3 && in_tog == 1, "R9 ack releases and flips", in_q.size(), 3);
        do_in(1, r);
        check(r == 1 && tx_got.size() == 3, "R9 next packet uses new toggle", tx_got.size(), 3);

        // R10 full packet then zero-length, then NAK
        feed(IN_MAX);
        repeat (12) tick();
        do_in(1, r);
        do_in(1, r);
        check(r == 1 && tx_got.size() == 0, "R10 zero-length after full", tx_got.size(), 0);
        do_in(1, r);
        check(r == 0, "R10 NAK after zero-length acked", r, 0);

        // R11 IN buffer full
        feed(IN_DEPTH + 4);
        repeat (30) tick();
        check(!app_in_ready, "R11 app_in_ready low when full", app_in_ready, 0);
        check(in_q.size() == IN_DEPTH, "R11 held byte count", in_q.size(), IN_DEPTH);
        for (int i = 0; i < 6; i++) do_in(1, r);

        // random traffic
        rdy_mode = 2;
        for (int it = 0; it < 300; it++) begin
            case ($urandom % 5)
                0, 1: begin
                    int len;
                    bit odd;
                    len = ($urandom % 8 == 0) ? OUT_MAX + 1 : int'($urandom % (OUT_MAX + 1));
                    odd = ($urandom % 5 == 0) ? ~out_tog : out_tog;
                    do_out(len, odd, r);
                end
                2: do_in(($urandom % 4) != 0, r);
                3: feed($urandom % 10);
                default: repeat ($urandom % 6) tick();
            endcase
        end

        // drain both sides
        rdy_mode = 1;
        for (int k = 0; k < 200 && exp_out_q.size() != 0; k++) tick();
        check(exp_out_q.size() == 0, "R2 final OUT drain", exp_out_q.size(), 0);
        for (int k = 0; k < 20 && (held || in_q.size() != 0 || feed_q.size() != 0 || zlp_pend); k++) begin
            do_in(1, r);
            repeat (4) tick();
        end
        check(in_q.size() == 0 && !held, "R9 final IN drain", in_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule